// File: doc/BRIEF.md
# Ethernet receive destination filter with status record

This block sits on the receive byte stream of an Ethernet MAC. It watches each frame as it arrives, latches the six destination bytes and keeps a running payload sum. When the last byte arrives it decides whether the frame is kept or dropped. A kept frame also gets a five-word status record. The decision comes from two stages in series. The basic stage compares the destination against a unicast address and a small set of exact multicast entries, and it honours separate reject switches for broadcast and multicast traffic. A promiscuous switch bypasses the basic stage. The extended stage is optional. It checks unicast frames against a second address and looks multicast frames up in a bitmap that a 15-bit hash of the destination indexes.

Length rules are applied to the frame. Frames shorter than 12 bytes are rejected and raise a sticky status flag, which can drive an interrupt. Frames of 1519 to 1522 bytes are dropped unless jumbo or VLAN sizes are enabled. Filter state is loaded through a write-only select/data port, and the hash bitmap through its own word-wide write port.

Top module: `eth_rx_filter`

## Requirements
- R1: A destination whose byte 0 has bit 0 clear is unicast, all six bytes 0xFF is broadcast, and anything else is multicast. Multicast that starts 01-00-52 is also IP multicast. Status word 2 carries bit 0 for multicast, bit 1 for IP multicast, bit 3 for broadcast and bit 6 for every kept frame.
- R2: An address register holds the destination with byte 0 in bits 7:0 of its low word and byte 5 in bits 15:8 of its high word. Select 1 writes the unicast low word and select 2 writes the unicast high word. Outside promiscuous mode, a unicast frame is kept only on an exact match.
- R3: Select 0 is the control word. Control bit 2 drops broadcast frames and control bit 1 drops multicast frames.
- R4: Select 5 is the index word, and its bits 1:0 choose which of four multicast entries selects 6 (low) and 7 (high) write. Outside promiscuous mode, a multicast frame is kept only if it equals one of the entries.
- R5: Bit 31 of the index word turns on promiscuous mode, which skips the basic stage.
- R6: With control bits 11 and 12 both set, the extended stage also applies. Unicast must then equal the second address (selects 3 and 4), broadcast obeys control bit 2, and IP multicast is dropped. Other multicast computes index = {byte4[6:0], byte5} and is kept only if bit index[4:0] of bitmap word index[14:5] is set. The bitmap is written through the table port and is clear after reset.
- R7: Select 8 is the receive configuration, with bit 0 for jumbo, bit 1 for VLAN and bit 2 for in-band FCS. When neither jumbo nor VLAN is set, frames of 1519 to 1522 bytes are dropped. Longer frames are not dropped by this rule.
- R8: A frame shorter than 12 bytes is always dropped and sets status bit 3. Writing select 9 clears the status bits that have a 1 in the data. If a set and a clear hit bit 3 in the same cycle, the set wins. Select 10 is the enable word, and irq is high while status AND enable is nonzero.
- R9: dec_valid pulses for exactly the one cycle after each end-of-frame beat, and dec_accept gives the verdict in that cycle. rec_valid is high in that cycle exactly when the frame is kept.
- R10: For a kept frame, record word 0 is 0x50000000 and word 1 is 0. Word 3 is the ones'-complement sum of the bytes from offset 14 to the end, read as big-endian 16-bit words, with an odd last byte padded with zero, folded twice to 16 bits. Word i sits in rec_data bits 32i+31:32i.
- R11: Record word 4 holds the frame length in bytes, plus 4 when in-band FCS is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte beat valid |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Frame byte |
| cfg_we | input | 1 | Filter register write strobe |
| cfg_sel | input | 4 | Filter register select |
| cfg_wdata | input | 32 | Filter register write data |
| tbl_we | input | 1 | Hash bitmap word write strobe |
| tbl_addr | input | HASH_BITS-5 | Hash bitmap word index |
| tbl_wdata | input | 32 | Hash bitmap word data |
| dec_valid | output | 1 | Verdict pulse |
| dec_accept | output | 1 | Verdict: frame kept |
| rec_valid | output | 1 | Status record valid |
| rec_data | output | 160 | Five-word status record |
| irq | output | 1 | Status AND enable nonzero |

## Verification
Two functions can meet on the short-frame status bit. A frame under 12 bytes can finish in the same cycle that a write-one-to-clear to that bit lands. The bench provokes this by driving the clear write on the end-of-frame beat of an 11-byte frame. The behavioural model applies the clear first and the set after it, and the bench then expects irq to stay high. The per-clock comparison of irq and dec_valid judges the result in the cycle after that edge and in every cycle after it, until a later clear drops the bit.

// File: rtl/eth_rxf_pkg.sv
package eth_rxf_pkg;

   localparam logic [3:0] SEL_CTRL   = 4'd0;
   localparam logic [3:0] SEL_UNI_LO = 4'd1;
   localparam logic [3:0] SEL_UNI_HI = 4'd2;
   localparam logic [3:0] SEL_EXT_LO = 4'd3;
   localparam logic [3:0] SEL_EXT_HI = 4'd4;
   localparam logic [3:0] SEL_INDEX  = 4'd5;
   localparam logic [3:0] SEL_MC_LO  = 4'd6;
   localparam logic [3:0] SEL_MC_HI  = 4'd7;
   localparam logic [3:0] SEL_RXCFG  = 4'd8;
   localparam logic [3:0] SEL_STAT   = 4'd9;
   localparam logic [3:0] SEL_ENABLE = 4'd10;

   localparam int CTRL_MC_REJ = 1;
   localparam int CTRL_BC_REJ = 2;
   localparam int CTRL_XA     = 11;
   localparam int CTRL_XB     = 12;
   localparam int IDX_PROMISC = 31;
   localparam int STAT_SHORT  = 3;

   localparam int REC_WORDS = 5;
   localparam int REC_BITS  = 32 * REC_WORDS;

   typedef struct packed {
      logic        mc_rej;
      logic        bc_rej;
      logic        ext_en;
      logic        promisc;
      logic        jumbo;
      logic        vlan;
      logic        fcs_in;
      logic [47:0] uni;
      logic [47:0] ext;
   } filt_cfg_t;

   // two folds of a 32-bit partial sum down to 16 bits
   function automatic logic [15:0] fold2(input logic [31:0] a);
      logic [16:0] s1;
      s1 = {1'b0, a[31:16]} + {1'b0, a[15:0]};
      return s1[15:0] + {15'h0, s1[16]};
   endfunction

endpackage

// File: rtl/eth_rxf_cfg.sv
module eth_rxf_cfg
   import eth_rxf_pkg::*;
#(
   parameter int MC_ENTRIES = 4,
   parameter int HASH_AW    = 10
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             cfg_we,
   input  logic [3:0]                       cfg_sel,
   input  logic [31:0]                      cfg_wdata,
   input  logic                             tbl_we,
   input  logic [HASH_AW-1:0]               tbl_addr,
   input  logic [31:0]                      tbl_wdata,
   input  logic                             short_set,
   input  logic [HASH_AW-1:0]               hash_sel,
   output filt_cfg_t                        cfg,
   output logic [MC_ENTRIES-1:0][47:0]      mc_addr,
   output logic [31:0]                      hash_word,
   output logic                             irq
);
   localparam int MSEL_W     = $clog2(MC_ENTRIES);
   localparam int HASH_WORDS = 1 << HASH_AW;

   logic              mc_rej_q, bc_rej_q, xa_q, xb_q, promisc_q;
   logic [MSEL_W-1:0] msel_q;
   logic [2:0]        rxcfg_q;
   logic [47:0]       uni_q, ext_q;
   logic [47:0]       mc_q [MC_ENTRIES];
   logic [31:0]       tbl_q [HASH_WORDS];
   logic [31:0]       stat_q, en_q, clr_mask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         {mc_rej_q, bc_rej_q, xa_q, xb_q, promisc_q} <= '0;
         msel_q  <= '0;
         rxcfg_q <= '0;
         uni_q   <= '0;
         ext_q   <= '0;
         en_q    <= '0;
         for (int i = 0; i < MC_ENTRIES; i++) mc_q[i] <= '0;
      end else if (cfg_we) begin
         case (cfg_sel)
            SEL_CTRL: begin
               mc_rej_q <= cfg_wdata[CTRL_MC_REJ];
               bc_rej_q <= cfg_wdata[CTRL_BC_REJ];
               xa_q     <= cfg_wdata[CTRL_XA];
               xb_q     <= cfg_wdata[CTRL_XB];
            end
            SEL_UNI_LO: uni_q[31:0]  <= cfg_wdata;
            SEL_UNI_HI: uni_q[47:32] <= cfg_wdata[15:0];
            SEL_EXT_LO: ext_q[31:0]  <= cfg_wdata;
            SEL_EXT_HI: ext_q[47:32] <= cfg_wdata[15:0];
            SEL_INDEX: begin
               promisc_q <= cfg_wdata[IDX_PROMISC];
               msel_q    <= cfg_wdata[MSEL_W-1:0];
            end
            SEL_MC_LO:  mc_q[msel_q][31:0]  <= cfg_wdata;
            SEL_MC_HI:  mc_q[msel_q][47:32] <= cfg_wdata[15:0];
            SEL_RXCFG:  rxcfg_q <= cfg_wdata[2:0];
            SEL_ENABLE: en_q    <= cfg_wdata;
            default: ;
         endcase
      end
   end

   // write-one-to-clear; a set in the same cycle wins
   assign clr_mask = (cfg_we && cfg_sel == SEL_STAT) ? cfg_wdata : 32'h0;

   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~clr_mask) | ({31'h0, short_set} << STAT_SHORT);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < HASH_WORDS; i++) tbl_q[i] <= '0;
      end else if (tbl_we) begin
         tbl_q[tbl_addr] <= tbl_wdata;
      end
   end

   for (genvar g = 0; g < MC_ENTRIES; g++) begin : g_mc_out
      assign mc_addr[g] = mc_q[g];
   end

   assign cfg.mc_rej  = mc_rej_q;
   assign cfg.bc_rej  = bc_rej_q;
   assign cfg.ext_en  = xa_q & xb_q;
   assign cfg.promisc = promisc_q;
   assign cfg.jumbo   = rxcfg_q[0];
   assign cfg.vlan    = rxcfg_q[1];
   assign cfg.fcs_in  = rxcfg_q[2];
   assign cfg.uni     = uni_q;
   assign cfg.ext     = ext_q;

   assign hash_word = tbl_q[hash_sel];
   assign irq       = |(stat_q & en_q);

endmodule

// File: rtl/eth_rxf_match.sv
module eth_rxf_match
   import eth_rxf_pkg::*;
#(
   parameter int MC_ENTRIES = 4,
   parameter int HASH_BITS  = 15,
   parameter bit HASH_EN    = 1'b1,
   parameter int LEN_W      = 16
) (
   input  filt_cfg_t                   cfg,
   input  logic [MC_ENTRIES-1:0][47:0] mc_addr,
   input  logic [47:0]                 dst,
   input  logic [LEN_W-1:0]            len,
   input  logic [31:0]                 hash_word,
   output logic [HASH_BITS-6:0]        hash_sel,
   output logic                        is_mc,
   output logic                        is_ip,
   output logic                        is_bc,
   output logic                        short_len,
   output logic                        accept
);
   logic                  is_uni, size_drop, basic_ok, ext_ok;
   logic [MC_ENTRIES-1:0] mc_hit;

   assign is_uni = ~dst[0];
   assign is_bc  = &dst;
   assign is_mc  = ~is_uni & ~is_bc;
   assign is_ip  = is_mc && (dst[23:0] == 24'h52_00_01);

   for (genvar g = 0; g < MC_ENTRIES; g++) begin : g_mc_cmp
      assign mc_hit[g] = (dst == mc_addr[g]);
   end

   assign short_len = (len < LEN_W'(12));
   assign size_drop = !cfg.jumbo && !cfg.vlan &&
                      (len >= LEN_W'(1519)) && (len <= LEN_W'(1522));

   always_comb begin
      if (cfg.promisc)  basic_ok = 1'b1;
      else if (is_uni)  basic_ok = (dst == cfg.uni);
      else if (is_bc)   basic_ok = !cfg.bc_rej;
      else              basic_ok = !cfg.mc_rej && (|mc_hit);
   end

   if (HASH_EN) begin : g_ext
      logic [14:0] hidx;
      logic        bit_on;
      assign hidx     = {dst[38:32], dst[47:40]};
      assign hash_sel = hidx[HASH_BITS-1:5];
      assign bit_on   = hash_word[hidx[4:0]];
      always_comb begin
         if (!cfg.ext_en)  ext_ok = 1'b1;
         else if (is_uni)  ext_ok = (dst == cfg.ext);
         else if (is_bc)   ext_ok = !cfg.bc_rej;
         else              ext_ok = !is_ip && bit_on;
      end
   end else begin : g_no_ext
      assign hash_sel = '0;
      assign ext_ok   = 1'b1;
   end

   assign accept = !short_len && !size_drop && basic_ok && ext_ok;

endmodule

// File: rtl/eth_rxf_sum.sv
module eth_rxf_sum #(
   parameter int LEN_W      = 16,
   parameter int CSUM_START = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic [LEN_W-1:0] pos,
   input  logic [7:0]       in_data,
   output logic [31:0]      sum_now
);
   localparam bit START_ODD = CSUM_START[0];

   logic [31:0] acc_q, base, term;

   assign base = in_sof ? 32'h0 : acc_q;

   always_comb begin
      if (pos < LEN_W'(CSUM_START))  term = 32'h0;
      else if (pos[0] ^ START_ODD)   term = {24'h0, in_data};
      else                           term = {16'h0, in_data, 8'h0};
   end

   assign sum_now = base + term;

   always_ff @(posedge clk) begin
      if (!rst_n)        acc_q <= '0;
      else if (in_valid) acc_q <= sum_now;
   end

endmodule

// File: rtl/eth_rx_filter.sv
module eth_rx_filter
   import eth_rxf_pkg::*;
#(
   parameter int LEN_W      = 16,
   parameter int MC_ENTRIES = 4,
   parameter int HASH_BITS  = 15,
   parameter bit HASH_EN    = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic                 in_sof,
   input  logic                 in_eof,
   input  logic [7:0]           in_data,
   input  logic                 cfg_we,
   input  logic [3:0]           cfg_sel,
   input  logic [31:0]          cfg_wdata,
   input  logic                 tbl_we,
   input  logic [HASH_BITS-6:0] tbl_addr,
   input  logic [31:0]          tbl_wdata,
   output logic                 dec_valid,
   output logic                 dec_accept,
   output logic                 rec_valid,
   output logic [REC_BITS-1:0]  rec_data,
   output logic                 irq
);
   localparam int HASH_AW = HASH_BITS - 5;

   if (LEN_W < 11 || LEN_W > 16) begin : g_bad_len
      $error("LEN_W must lie in 11..16");
   end
   if (MC_ENTRIES < 2 || (MC_ENTRIES & (MC_ENTRIES - 1)) != 0) begin : g_bad_mc
      $error("MC_ENTRIES must be a power of two, at least 2");
   end
   if (HASH_BITS < 6 || HASH_BITS > 15) begin : g_bad_hash
      $error("HASH_BITS must lie in 6..15");
   end

   filt_cfg_t                   cfg;
   logic [MC_ENTRIES-1:0][47:0] mc_addr;
   logic [31:0]                 hash_word, sum_now;
   logic [HASH_AW-1:0]          hash_sel;
   logic [LEN_W-1:0]            cnt_q, pos, len_now;
   logic [47:0]                 dst_q;
   logic                        is_mc, is_ip, is_bc, short_len, accept, eof_beat;
   logic [15:0]                 len_rec;
   logic [31:0]                 class_word;

   assign pos      = in_sof ? '0 : cnt_q;
   assign len_now  = (&pos) ? pos : pos + LEN_W'(1);
   assign eof_beat = in_valid && in_eof;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         dst_q <= '0;
      end else if (in_valid) begin
         cnt_q <= len_now;
         for (int b = 0; b < 6; b++) begin
            if (pos == LEN_W'(b)) dst_q[b*8 +: 8] <= in_data;
         end
      end
   end

   eth_rxf_cfg #(.MC_ENTRIES(MC_ENTRIES), .HASH_AW(HASH_AW)) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
      .short_set(eof_beat && short_len), .hash_sel(hash_sel),
      .cfg(cfg), .mc_addr(mc_addr), .hash_word(hash_word), .irq(irq)
   );

   eth_rxf_match #(.MC_ENTRIES(MC_ENTRIES), .HASH_BITS(HASH_BITS),
                   .HASH_EN(HASH_EN), .LEN_W(LEN_W)) u_match (
      .cfg(cfg), .mc_addr(mc_addr), .dst(dst_q), .len(len_now),
      .hash_word(hash_word), .hash_sel(hash_sel),
      .is_mc(is_mc), .is_ip(is_ip), .is_bc(is_bc),
      .short_len(short_len), .accept(accept)
   );

   eth_rxf_sum #(.LEN_W(LEN_W), .CSUM_START(14)) u_sum (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .pos(pos), .in_data(in_data), .sum_now(sum_now)
   );

   assign len_rec    = 16'(len_now) + (cfg.fcs_in ? 16'd4 : 16'd0);
   assign class_word = {25'h0, 1'b1, 2'b00, is_bc, 1'b0, is_ip, is_mc};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         dec_accept <= 1'b0;
         rec_valid  <= 1'b0;
         rec_data   <= '0;
      end else begin
         dec_valid  <= eof_beat;
         dec_accept <= eof_beat && accept;
         rec_valid  <= eof_beat && accept;
         if (eof_beat && accept) begin
            rec_data <= {16'h0, len_rec, 16'h0, fold2(sum_now),
                         class_word, 32'h0, 32'h5000_0000};
         end
      end
   end

endmodule

// File: rtl/eth_rx_filter_chk.sv
module eth_rx_filter_chk #(
   parameter int LEN_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_sof,
   input logic             in_eof,
   input logic [LEN_W-1:0] pos,
   input logic             dec_valid,
   input logic             dec_accept,
   input logic             rec_valid,
   input logic [159:0]     rec_data
);
   // R9
   dec_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> $past(in_valid && in_eof));

   // R9
   rec_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> (dec_valid && dec_accept));

   // R10
   rec_header_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> (rec_data[31:0] == 32'h5000_0000 && rec_data[63:32] == 32'h0 && rec_data[70]));

   // R8
   short_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_eof && (in_sof || pos < LEN_W'(11))) |=> (dec_valid && !dec_accept));

   // R1
   class_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> ($onehot0({rec_data[64], rec_data[67]}) && (!rec_data[65] || rec_data[64])));

endmodule

bind eth_rx_filter eth_rx_filter_chk #(.LEN_W(LEN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
   .in_eof(in_eof), .pos(pos), .dec_valid(dec_valid), .dec_accept(dec_accept),
   .rec_valid(rec_valid), .rec_data(rec_data)
);

// File: tb/sim_eth_rx_filter.sv
module sim_eth_rx_filter;
   typedef bit [7:0] bq_t[$];

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
   logic [7:0]   in_data = 8'h0;
   logic         cfg_we = 1'b0;
   logic [3:0]   cfg_sel = 4'h0;
   logic [31:0]  cfg_wdata = 32'h0;
   logic         tbl_we = 1'b0;
   logic [9:0]   tbl_addr = 10'h0;
   logic [31:0]  tbl_wdata = 32'h0;
   logic         dec_valid, dec_accept, rec_valid, irq;
   logic [159:0] rec_data;

   always #5 clk = ~clk;

   eth_rx_filter u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .in_eof(in_eof), .in_data(in_data), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
      .tbl_wdata(tbl_wdata), .dec_valid(dec_valid), .dec_accept(dec_accept),
      .rec_valid(rec_valid), .rec_data(rec_data), .irq(irq)
   );

   int total = 0, bad = 0;
   bit run = 0, done = 0;
   bit exp_dv = 0, exp_irq = 0;

   // behavioural model state
   bit [31:0] m_ctrl, m_idx, m_rxcfg, m_en;
   bit [47:0] m_uni, m_ext;
   bit [47:0] m_mc [4];
   bit [31:0] m_tbl [1024];
   bit        m_short;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [159:0] act, input logic [159:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      #2;
      if (run && !done) begin
         chk(dec_valid === exp_dv, "R9", "dec_valid per clock", 160'(dec_valid), 160'(exp_dv));
         chk(irq === exp_irq, "R8", "irq per clock", 160'(irq), 160'(exp_irq));
      end
   end

   function automatic bq_t mk(input bit [47:0] da, input int n, input int seed);
      bq_t q;
      for (int i = 0; i < n; i++) begin
         if (i < 6) q.push_back(da[8*i +: 8]);
         else       q.push_back(8'((i * 13 + seed) & 255));
      end
      return q;
   endfunction

   function automatic bit model(input bq_t f, output bit [159:0] rec);
      int n;
      bit [47:0] d;
      bit uni, bc, mc, ip, hit;
      bit [14:0] hidx;
      bit [31:0] s, s1;
      bit [15:0] c, ln;
      n = f.size();
      rec = '0;
      d = '0;
      for (int i = 0; i < 6 && i < n; i++) d[8*i +: 8] = f[i];
      uni = !d[0];
      bc  = (d == 48'hFFFF_FFFF_FFFF);
      mc  = !uni && !bc;
      ip  = mc && d[7:0] == 8'h01 && d[15:8] == 8'h00 && d[23:16] == 8'h52;
      if (n < 12) return 1'b0;
      if (!m_rxcfg[0] && !m_rxcfg[1] && n >= 1519 && n <= 1522) return 1'b0;
      if (!m_idx[31]) begin
         if (uni) begin
            if (d != m_uni) return 1'b0;
         end else if (bc) begin
            if (m_ctrl[2]) return 1'b0;
         end else begin
            if (m_ctrl[1]) return 1'b0;
            hit = 0;
            for (int k = 0; k < 4; k++) if (d == m_mc[k]) hit = 1;
            if (!hit) return 1'b0;
         end
      end
      if (m_ctrl[11] && m_ctrl[12]) begin
         if (uni) begin
            if (d != m_ext) return 1'b0;
         end else if (bc) begin
            if (m_ctrl[2]) return 1'b0;
         end else begin
            if (ip) return 1'b0;
            hidx = {d[38:32], d[47:40]};
            if (!m_tbl[hidx[14:5]][hidx[4:0]]) return 1'b0;
         end
      end
      s = 0;
      for (int p = 14; p < n; p++) begin
         if (p % 2 == 0) s = s + {16'h0, f[p], 8'h0};
         else            s = s + {24'h0, f[p]};
      end
      s1 = {16'h0, s[15:0]} + {16'h0, s[31:16]};
      c  = s1[15:0] + s1[31:16];
      ln = 16'(n) + (m_rxcfg[2] ? 16'd4 : 16'd0);
      rec[31:0]    = 32'h5000_0000;
      rec[95:64]   = {25'h0, 1'b1, 2'b00, bc, 1'b0, ip, mc};
      rec[127:96]  = {16'h0, c};
      rec[159:128] = {16'h0, ln};
      return 1'b1;
   endfunction

   task automatic wr(input bit [3:0] s, input bit [31:0] d);
      @(negedge clk);
      cfg_we = 1; cfg_sel = s; cfg_wdata = d;
      case (s)
         4'd0:  m_ctrl = d;
         4'd1:  m_uni[31:0] = d;
         4'd2:  m_uni[47:32] = d[15:0];
         4'd3:  m_ext[31:0] = d;
         4'd4:  m_ext[47:32] = d[15:0];
         4'd5:  m_idx = d;
         4'd6:  m_mc[m_idx[1:0]][31:0] = d;
         4'd7:  m_mc[m_idx[1:0]][47:32] = d[15:0];
         4'd8:  m_rxcfg = d;
         4'd9:  if (d[3]) m_short = 0;
         4'd10: m_en = d;
         default: ;
      endcase
      exp_irq = m_short && m_en[3];
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic wr_addr(input bit [3:0] lo_sel, input bit [47:0] a);
      wr(lo_sel, a[31:0]);
      wr(lo_sel + 4'd1, {16'h0, a[47:32]});
   endtask

   task automatic wr_tbl(input bit [9:0] a, input bit [31:0] d);
      @(negedge clk);
      tbl_we = 1; tbl_addr = a; tbl_wdata = d;
      m_tbl[a] = d;
      @(negedge clk);
      tbl_we = 0;
   endtask

   task automatic send(input bq_t f, input bit clr_same, input string req);
      bit        exp_acc;
      bit [159:0] exp_rec;
      int        n;
      n = f.size();
      exp_acc = model(f, exp_rec);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1; in_sof = (i == 0); in_eof = (i == n - 1); in_data = f[i];
         if (i == n - 1) begin
            exp_dv = 1;
            if (clr_same) begin
               cfg_we = 1; cfg_sel = 4'd9; cfg_wdata = 32'h8;
               m_short = 0;
            end
            if (n < 12) m_short = 1;
            exp_irq = m_short && m_en[3];
         end else begin
            exp_dv = 0;
         end
      end
      @(negedge clk);
      in_valid = 0; in_sof = 0; in_eof = 0; cfg_we = 0; exp_dv = 0;
      chk(dec_accept === exp_acc, req, "verdict", 160'(dec_accept), 160'(exp_acc));
      chk(rec_valid === exp_acc, req, "rec_valid", 160'(rec_valid), 160'(exp_acc));
      if (exp_acc) chk(rec_data === exp_rec, req, "record (R10 R11)", rec_data, exp_rec);
   endtask

   localparam bit [47:0] UA  = 48'h6655_4433_2210;
   localparam bit [47:0] UB  = 48'h6655_4433_2212;
   localparam bit [47:0] EA  = 48'h6655_4433_2220;
   localparam bit [47:0] BC  = 48'hFFFF_FFFF_FFFF;
   localparam bit [47:0] M1  = 48'hA988_7766_5501;
   localparam bit [47:0] M2  = 48'hA988_7766_5503;
   localparam bit [47:0] IPM = 48'h0C0B_0A52_0001;
   localparam bit [47:0] HM  = 48'h4583_3322_0101;
   localparam bit [47:0] HMN = 48'h4483_3322_0101;
   localparam bit [47:0] HMM = 48'h4503_3322_0101;

   initial begin
      repeat (3) @(negedge clk);
      chk(dec_valid === 1'b0, "R9", "reset dec_valid", 160'(dec_valid), 160'd0);
      chk(rec_valid === 1'b0, "R9", "reset rec_valid", 160'(rec_valid), 160'd0);
      chk(irq === 1'b0, "R8", "reset irq", 160'(irq), 160'd0);
      rst_n = 1;
      run = 1;

      // R2 unicast exact match, R1 unicast class word
      wr_addr(4'd1, UA);
      send(mk(UA, 64, 1), 0, "R2");
      send(mk(UB, 64, 2), 0, "R2");
      // R1 broadcast, R3 broadcast reject
      send(mk(BC, 60, 3), 0, "R1");
      wr(4'd0, 32'h4);
      send(mk(BC, 60, 3), 0, "R3");
      // R4 multicast entries
      wr(4'd5, 32'h1);
      wr_addr(4'd6, M1);
      wr(4'd5, 32'h0);
      send(mk(M1, 70, 4), 0, "R4");
      send(mk(M2, 70, 4), 0, "R4");
      wr(4'd0, 32'h6);
      send(mk(M1, 70, 4), 0, "R3");
      wr(4'd0, 32'h0);
      // R5 promiscuous
      wr(4'd5, 32'h8000_0000);
      send(mk(UB, 40, 9), 0, "R5");
      send(mk(IPM, 40, 10), 0, "R1");
      // R6 extended stage
      wr(4'd0, 32'h1800);
      wr_tbl(10'd26, 32'h20);
      wr_addr(4'd3, EA);
      send(mk(HM, 50, 11), 0, "R6");
      send(mk(HMN, 50, 11), 0, "R6");
      send(mk(HMM, 50, 12), 0, "R6");
      send(mk(IPM, 50, 12), 0, "R6");
      send(mk(EA, 50, 13), 0, "R6");
      send(mk(UA, 50, 13), 0, "R6");
      wr(4'd0, 32'h0);
      wr(4'd5, 32'h0);
      // R7 size window
      send(mk(UA, 1519, 14), 0, "R7");
      send(mk(UA, 1522, 15), 0, "R7");
      send(mk(UA, 1523, 16), 0, "R7");
      wr(4'd8, 32'h2);
      send(mk(UA, 1520, 17), 0, "R7");
      wr(4'd8, 32'h1);
      send(mk(UA, 1521, 18), 0, "R7");
      // R11 in-band FCS length, odd-length sum
      wr(4'd8, 32'h4);
      send(mk(UA, 61, 19), 0, "R11");
      wr(4'd8, 32'h0);
      send(mk(UA, 15, 20), 0, "R10");
      // R8 short frames, status and enable
      send(mk(UA, 11, 21), 0, "R8");
      wr(4'd10, 32'h8);
      chk(irq === 1'b1, "R8", "irq after enable", 160'(irq), 160'd1);
      wr(4'd9, 32'h4);
      chk(irq === 1'b1, "R8", "clear of other bit", 160'(irq), 160'd1);
      wr(4'd9, 32'h8);
      chk(irq === 1'b0, "R8", "irq after clear", 160'(irq), 160'd0);
      send(mk(UA, 12, 22), 0, "R8");
      send(mk(UA, 11, 23), 1, "R8");
      chk(irq === 1'b1, "R8", "set wins over clear", 160'(irq), 160'd1);
      wr(4'd9, 32'h8);
      repeat (2) @(negedge clk);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule